// File: doc/BRIEF.md
# Multichannel Output Slot Interleaver

This block sits between the playback DMA and the AC'97 link framer. It takes one interleaved stream of 32-bit words and spreads the samples it carries over the output slots 3 to 11 of a link frame. A 9-bit enable mask chooses which slots take part. A mode input chooses one of two fixed fill orders: surround pair before center/LFE, or center/LFE before the surround pair. Each stream word carries either one 32-bit sample or two 16-bit samples.

Samples are gathered into a frame buffer, one slot at a time, in fill order. Disabled slots are passed over. Once every enabled slot holds a sample, the stream is stalled. At each frame boundary pulse from the link side, the buffer is handed over on a one-cycle strobe with a valid bit per slot, and filling starts again. A frame that is still short at the boundary goes out with the missing slots marked invalid. A write-only configuration word holds the slot mask and a 5-bit FIFO fill threshold, and the threshold is shown on an output.

Top module: `slot_interleaver`

## Requirements
- R1: A configuration write (`cfg_we` high at a clock edge) loads `cfg_wdata[8:0]` as the slot mask and `cfg_wdata[15:11]` as the threshold. The threshold appears on `fifo_thresh` one cycle later. Bits 10:9 are ignored. After reset the mask and the threshold are both zero.
- R2: Mask bit k enables output slot k+3. Slot 5 (bit 2) is an input slot: it never receives a sample and its valid bit `out_vld[2]` is always 0, even when mask bit 2 is set.
- R3: With `reorder_en` low, samples fill the enabled slots in the order 3, 4, 7, 8, 6, 9, 10, 11.
- R4: With `reorder_en` high, samples fill the enabled slots in the order 3, 4, 6, 9, 7, 8, 10, 11.
- R5: A disabled slot is skipped, and the next sample goes to the next enabled slot in the active order.
- R6: With `half_mode` low, each accepted word is one sample and is stored in full in one slot.
- R7: With `half_mode` high, each accepted word holds two 16-bit samples. Bits 15:0 go to the earlier enabled slot and bits 31:16 go to the next enabled slot, each placed in bits 15:0 of the slot word with bits 31:16 zero. If no later enabled slot remains, the upper half is dropped.
- R8: `in_ready` is low while every enabled slot already holds a sample, and also when no slot is enabled. It is low after reset.
- R9: A `frame_req` pulse makes `out_stb` high for exactly the next cycle. In that cycle `out_data` (slot k+3 at bits `32*k+31:32*k`) and `out_vld` show the collected frame. The following word goes to the first enabled slot of a new frame.
- R10: An enabled slot that has no sample at the frame boundary is handed over with its valid bit 0 and data 0.
- R11: `in_ready` is low in any cycle where `frame_req` is high, so no word is taken at a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word: slot mask at 8:0, threshold at 15:11 |
| reorder_en | input | 1 | Selects the center/LFE-first fill order |
| half_mode | input | 1 | Two 16-bit samples per word when high |
| in_valid | input | 1 | Stream word valid |
| in_data | input | 32 | Stream word |
| in_ready | output | 1 | Stream word accepted when high together with in_valid |
| frame_req | input | 1 | Frame boundary pulse from the link side |
| out_stb | output | 1 | Frame hand-over strobe |
| out_data | output | 288 | Slot words, slot k+3 at bits 32k+31:32k |
| out_vld | output | 9 | Per-slot valid, bit k for slot k+3 |
| fifo_thresh | output | 5 | Stored FIFO fill threshold |

## Verification
The fill order is checked with all slots enabled and distinct words, once per order mode. A wrong entry in either order table then shows up as swapped slot contents. A 4-channel mask with a gap in the default order separates skipping from plain positional placement. A 16-bit run on a 4-slot mask checks the half-word split, and a 3-slot mask checks that the odd upper half is dropped. A short frame checks partial hand-over and the restart at slot 3, and a frame-boundary probe confirms that the stream is held off during the boundary.

// File: rtl/slot_interleaver.sv
module slot_interleaver #(
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [15:0]        cfg_wdata,
  input  logic               reorder_en,
  input  logic               half_mode,
  input  logic               in_valid,
  input  logic [DW-1:0]      in_data,
  output logic               in_ready,
  input  logic               frame_req,
  output logic               out_stb,
  output logic [9*DW-1:0]    out_data,
  output logic [8:0]         out_vld,
  output logic [4:0]         fifo_thresh
);
  localparam int NS = 9;
  localparam int HW = DW / 2;
  localparam logic [3:0] ENDP = 4'd8;

  logic [NS-1:0] mask;
  logic [DW-1:0] sbuf [NS];
  logic [NS-1:0] bvalid;
  logic [3:0]    pos;
  logic [3:0]    p1, p2;
  logic          acc;

  function automatic logic [3:0] slot_of(input logic [3:0] p, input logic ro);
    case (p)
      4'd0: slot_of = 4'd0;
      4'd1: slot_of = 4'd1;
      4'd2: slot_of = ro ? 4'd3 : 4'd4;
      4'd3: slot_of = ro ? 4'd6 : 4'd5;
      4'd4: slot_of = ro ? 4'd4 : 4'd3;
      4'd5: slot_of = ro ? 4'd5 : 4'd6;
      4'd6: slot_of = 4'd7;
      default: slot_of = 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] first_en(input logic [3:0] from, input logic [NS-1:0] m,
                                          input logic ro);
    first_en = ENDP;
    for (int i = 7; i >= 0; i--)
      if (i >= int'(from) && m[slot_of(4'(i), ro)]) first_en = 4'(i);
  endfunction

  assign p1          = first_en(pos, mask, reorder_en);
  assign p2          = first_en(p1 + 4'd1, mask, reorder_en);
  assign in_ready    = (p1 != ENDP) && !frame_req;
  assign acc         = in_valid && in_ready;
  assign fifo_thresh = fifo_thr_q;

  logic [4:0] fifo_thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask       <= '0;
      fifo_thr_q <= '0;
    end else if (cfg_we) begin
      mask       <= cfg_wdata[8:0];
      fifo_thr_q <= cfg_wdata[15:11];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      bvalid <= '0;
      for (int i = 0; i < NS; i++) sbuf[i] <= '0;
    end else if (frame_req) begin
      pos    <= '0;
      bvalid <= '0;
    end else if (acc) begin
      if (!half_mode) begin
        sbuf[slot_of(p1, reorder_en)]   <= in_data;
        bvalid[slot_of(p1, reorder_en)] <= 1'b1;
        pos <= p1 + 4'd1;
      end else begin
        sbuf[slot_of(p1, reorder_en)]   <= {{(DW-HW){1'b0}}, in_data[HW-1:0]};
        bvalid[slot_of(p1, reorder_en)] <= 1'b1;
        if (p2 != ENDP) begin
          sbuf[slot_of(p2, reorder_en)]   <= {{(DW-HW){1'b0}}, in_data[DW-1:HW]};
          bvalid[slot_of(p2, reorder_en)] <= 1'b1;
          pos <= p2 + 4'd1;
        end else begin
          pos <= ENDP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_stb  <= 1'b0;
      out_vld  <= '0;
      out_data <= '0;
    end else begin
      out_stb <= frame_req;
      if (frame_req) begin
        out_vld <= bvalid;
        for (int i = 0; i < NS; i++)
          out_data[DW*i +: DW] <= bvalid[i] ? sbuf[i] : '0;
      end
    end
  end

  assert_slot5_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld[2] == 1'b0);

  assert_one_per_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !half_mode) |=> $countones(bvalid) == $countones($past(bvalid)) + 1);

  assert_two_per_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && half_mode && p2 != ENDP) |=> $countones(bvalid) == $countones($past(bvalid)) + 2);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req |=> (bvalid == '0 && pos == 4'd0));

  assert_pos_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= ENDP);
endmodule

// File: tb/tb_slot_interleaver.sv
module tb_slot_interleaver;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [15:0] cfg_wdata = 0;
  logic reorder_en = 0, half_mode = 0, in_valid = 0, frame_req = 0;
  logic [31:0] in_data = 0;
  logic in_ready, out_stb;
  logic [287:0] out_data;
  logic [8:0] out_vld;
  logic [4:0] fifo_thresh;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] ed [9];
  logic [8:0] ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_interleaver dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .reorder_en(reorder_en), .half_mode(half_mode), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .frame_req(frame_req),
    .out_stb(out_stb), .out_data(out_data), .out_vld(out_vld),
    .fifo_thresh(fifo_thresh));

  task automatic check(input string req, input logic [287:0] act, input logic [287:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_exp();
    for (int i = 0; i < 9; i++) ed[i] = 0;
    ev = 0;
  endtask

  task automatic put(input int slot, input logic [31:0] d);
    ed[slot-3] = d;
    ev[slot-3] = 1'b1;
  endtask

  task automatic cfg(input logic [8:0] m, input logic [4:0] th);
    @(negedge clk);
    cfg_we = 1;
    cfg_wdata = {th, 2'b11, m};
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [31:0] w);
    int n = 0;
    @(negedge clk);
    in_valid = 1;
    in_data = w;
    while (!in_ready && n < 50) begin
      @(negedge clk);
      n++;
    end
    if (!in_ready) check("R8 ready stuck", 0, 1);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic frame(input string req);
    logic [287:0] ef;
    @(negedge clk);
    frame_req = 1;
    #1 check("R11 ready during boundary", {287'b0, in_ready}, 0);
    @(posedge clk);
    #1 frame_req = 0;
    @(negedge clk);
    for (int i = 0; i < 9; i++) ef[32*i +: 32] = ed[i];
    check({req, " strobe R9"}, {287'b0, out_stb}, 1);
    check({req, " valid"}, {279'b0, out_vld}, {279'b0, ev});
    check({req, " data"}, out_data, ef);
    @(negedge clk);
    check("R9 strobe one cycle", {287'b0, out_stb}, 0);
  endtask

  task automatic t_reset();
    check("R8 ready low after reset", {287'b0, in_ready}, 0);
    check("R1 threshold reset", {283'b0, fifo_thresh}, 0);
    check("R9 no strobe at reset", {287'b0, out_stb}, 0);
  endtask

  task automatic t_default_order();
    cfg(9'h1FF, 5'h15);
    check("R1 threshold field", {283'b0, fifo_thresh}, 288'h15);
    reorder_en = 0; half_mode = 0;
    clear_exp();
    for (int i = 0; i < 8; i++) send(32'hA000_0000 + i);
    put(3, 32'hA0000000); put(4, 32'hA0000001); put(7, 32'hA0000002);
    put(8, 32'hA0000003); put(6, 32'hA0000004); put(9, 32'hA0000005);
    put(10, 32'hA0000006); put(11, 32'hA0000007);
    @(negedge clk);
    check("R8 ready low when full", {287'b0, in_ready}, 0);
    frame("R3 R6 R2 default order");
  endtask

  task automatic t_reorder();
    reorder_en = 1;
    clear_exp();
    for (int i = 0; i < 8; i++) send(32'hB000_0000 + i);
    put(3, 32'hB0000000); put(4, 32'hB0000001); put(6, 32'hB0000002);
    put(9, 32'hB0000003); put(7, 32'hB0000004); put(8, 32'hB0000005);
    put(10, 32'hB0000006); put(11, 32'hB0000007);
    frame("R4 reorder");
    reorder_en = 0;
  endtask

  task automatic t_skip();
    cfg(9'h04B, 5'h0);
    clear_exp();
    for (int i = 0; i < 4; i++) send(32'hC000_0000 + i);
    put(3, 32'hC0000000); put(4, 32'hC0000001);
    put(6, 32'hC0000002); put(9, 32'hC0000003);
    @(negedge clk);
    check("R8 ready low after four", {287'b0, in_ready}, 0);
    frame("R5 skip");
  endtask

  task automatic t_half();
    cfg(9'h033, 5'h0);
    half_mode = 1;
    clear_exp();
    send(32'h2222_1111);
    send(32'h4444_3333);
    put(3, 32'h1111); put(4, 32'h2222); put(7, 32'h3333); put(8, 32'h4444);
    @(negedge clk);
    check("R8 ready low after two words", {287'b0, in_ready}, 0);
    frame("R7 half split");
  endtask

  task automatic t_half_odd();
    cfg(9'h013, 5'h0);
    half_mode = 1;
    clear_exp();
    send(32'h6666_5555);
    send(32'h8888_7777);
    put(3, 32'h5555); put(4, 32'h6666); put(7, 32'h7777);
    @(negedge clk);
    check("R7 ready low after odd", {287'b0, in_ready}, 0);
    frame("R7 odd drop");
    half_mode = 0;
  endtask

  task automatic t_partial();
    cfg(9'h1FF, 5'h0);
    clear_exp();
    send(32'hD0); send(32'hD1); send(32'hD2);
    put(3, 32'hD0); put(4, 32'hD1); put(7, 32'hD2);
    frame("R10 partial");
    clear_exp();
    send(32'hE0);
    put(3, 32'hE0);
    frame("R9 restart");
  endtask

  task automatic t_empty_mask();
    cfg(9'h004, 5'h0);
    @(negedge clk);
    check("R2 R8 ready low with only slot 5", {287'b0, in_ready}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_default_order();
    t_reorder();
    t_skip();
    t_half();
    t_half_odd();
    t_partial();
    t_empty_mask();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule